// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds a 24-bit single-error-correcting Hamming code over one NAND data sector while the sector's bytes stream through the controller, during either a page program or a page read. Every data bit takes part in two groups of parity. The first group, the column parities, splits the eight bit positions of a byte into halves by bit-index bit k. The second group, the line parities, splits the bytes of the sector into halves by byte-address bit k. Each parity is kept in two forms. The "even" form covers the half where the selecting bit is 0, and the "odd" form covers the half where it is 1. The code is not inverted, so an all-zero sector produces an all-zero code.

Software clears the generator before a sector. It then sets the enable and the bus width and streams the data beats through. A beat carries one byte in narrow mode and two bytes in wide mode. The generator counts bytes against a programmed sector length and stops absorbing data when the sector is full. After that, the parity word is available in a 32-bit result layout and also as three packed code bytes. A read path compares these code bytes against the bytes stored in the spare area. A single flipped data bit changes the code so that the odd half spells out the failing byte address and bit index, and the even half spells out their complement.

Control is a three-state machine:
- `S_IDLE`: cleared, waiting for data.
- `S_RUN`: part of the sector has been absorbed.
- `S_DONE`: the sector is complete, and further beats are dropped.

It has three named transitions:
- T_START (`S_IDLE` to `S_RUN`): the first accepted beat that does not fill the sector.
- T_FINISH (`S_IDLE` or `S_RUN` to `S_DONE`): the accepted beat that reaches the sector length.
- T_CLEAR (any state to `S_IDLE`): `clr` is asserted.

Top module: `nand_hamming_gen`

## Requirements
- R1: After reset, `result` and `code` are all zero and `done` is low.
- R2: Column parities work as follows. For k in 0..2, odd parity bit k is the XOR of every absorbed data bit whose bit index has bit k set, and even parity bit k is the XOR of every absorbed bit whose bit index has bit k clear. Even bit k sits in `result[k]` and odd bit k sits in `result[16+k]`.
- R3: Line parities work as follows. For k in 0..8, odd parity bit 3+k is the XOR of all bits of the bytes whose byte address has bit k set, and even bit 3+k covers the bytes where that bit is clear. Even bit j sits in `result[j]` and odd bit j sits in `result[16+j]` (j = 3..11). All other result bits are zero.
- R4: The packed code is laid out as follows:
  - `code[7:0]` holds even bits 7..0.
  - `code[15:8]` holds odd bits 7..0.
  - `code[19:16]` holds even bits 11..8.
  - `code[23:20]` holds odd bits 11..8.
- R5: In narrow mode (`wide`=0), an accepted beat absorbs the single byte `din[7:0]` at the current byte address, and the address then advances by one. `din[15:8]` has no effect.
- R6: In wide mode (`wide`=1), an accepted beat absorbs `din[7:0]` at the current address and `din[15:8]` at the next address, and the address then advances by two. A byte whose address would reach the sector length is dropped.
- R7: The sector holds 2*(`sect_units`+1) bytes. `done` rises in the cycle after the beat that reaches that count. While `done` is high, beats change nothing until the next clear.
- R8: When `clr` is high at a clock edge, all parities are zeroed, the byte address returns to 0 and `done` drops. A beat presented in the same cycle is discarded.
- R9: A beat is accepted only when `en` and `din_valid` are both high. Otherwise the parities and the byte address are left unchanged.
- R10: A sector made entirely of zero bytes yields a code of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear parities and restart the sector |
| en | input | 1 | Accumulation enable |
| wide | input | 1 | 0 = one byte per beat, 1 = two bytes per beat |
| sect_units | input | 8 | Sector length in 16-bit units, minus one |
| din | input | 16 | Data beat (low byte first) |
| din_valid | input | 1 | Beat strobe |
| result | output | 32 | Even parities in bits 11:0, odd parities in bits 27:16 |
| code | output | 24 | Three packed code bytes |
| done | output | 1 | Sector complete |

## Verification
The bench targets several corner cases of this block:
- A single flipped bit anywhere in a full 512-byte sector, including the last byte and the top bit. If address or bit weighting were wrong, the XOR of the two codes would not decode to the flipped position.
- A one-beat sector in wide mode, where the state machine jumps straight from `S_IDLE` to `S_DONE`.
- A switch from narrow to wide mode at an odd address, where a design that drops the overflow byte wrongly or mis-steps the address would disagree with the model.
- A clear that coincides with a beat, beats with the strobe or enable held low, and beats after completion. Each of these must leave the parities untouched, or a wrong design would fold stray bytes into the code.

// File: rtl/nand_hpar_pkg.sv
package nand_hpar_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } hp_state_e;

    // number of column parity pairs (bit index within a byte)
    localparam int COL_BITS = 3;
    // bit width of the result word and base of its odd half
    localparam int RESULT_W = 32;
    localparam int ODD_BASE = 16;
    // bytes carried by one wide beat
    localparam int LANES    = 2;

endpackage

// File: rtl/nand_hpar_lane.sv
// Parity contribution of one data byte at a given byte address.
module nand_hpar_lane
    import nand_hpar_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAR_W  = COL_BITS + ADDR_W
) (
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [PAR_W-1:0]  even_o,
    output logic [PAR_W-1:0]  odd_o
);

    logic row_par;

    assign row_par = ^byte_i;

    always_comb begin
        even_o = '0;
        odd_o  = '0;
        // column parities: split bit positions by index bit k
        for (int k = 0; k < COL_BITS; k++) begin
            for (int i = 0; i < 8; i++) begin
                if (((i >> k) & 1) == 1) begin
                    odd_o[k] = odd_o[k] ^ byte_i[i];
                end else begin
                    even_o[k] = even_o[k] ^ byte_i[i];
                end
            end
        end
        // line parities: whole-byte parity steered by address bit k
        for (int k = 0; k < ADDR_W; k++) begin
            if (addr_i[k]) begin
                odd_o[COL_BITS+k] = row_par;
            end else begin
                even_o[COL_BITS+k] = row_par;
            end
        end
        if (!en_i) begin
            even_o = '0;
            odd_o  = '0;
        end
    end

endmodule

// File: rtl/nand_hpar_ctrl.sv
// Sector sequencing: byte address, lane enables and completion state.
module nand_hpar_ctrl
    import nand_hpar_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int ADDR_W = SIZE_W + 1,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              valid_i,
    input  logic              wide_i,
    input  logic [SIZE_W-1:0] sect_units_i,
    output logic              take_o,
    output logic              lane0_en_o,
    output logic              lane1_en_o,
    output logic [ADDR_W-1:0] lane0_addr_o,
    output logic [ADDR_W-1:0] lane1_addr_o,
    output logic              done_o
);

    hp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] next_cnt;
    logic [CNT_W-1:0] cnt_plus1;
    logic             finish;

    // sector length in bytes = 2 * (units + 1)
    assign total     = CNT_W'({sect_units_i, 1'b0}) + CNT_W'(2);
    assign step      = wide_i ? CNT_W'(2) : CNT_W'(1);
    assign next_cnt  = cnt_q + step;
    assign cnt_plus1 = cnt_q + CNT_W'(1);

    assign take_o       = en_i && valid_i && !clr_i && (state_q != S_DONE);
    assign lane0_en_o   = take_o;
    assign lane1_en_o   = take_o && wide_i && (cnt_plus1 < total);
    assign lane0_addr_o = cnt_q[ADDR_W-1:0];
    assign lane1_addr_o = cnt_plus1[ADDR_W-1:0];
    assign finish       = take_o && (next_cnt >= total);

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = S_IDLE;                     // T_CLEAR
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (finish) begin
                        state_d = S_DONE;         // T_FINISH
                    end else if (take_o) begin
                        state_d = S_RUN;          // T_START
                    end
                end
                S_RUN: begin
                    if (finish) begin
                        state_d = S_DONE;         // T_FINISH
                    end
                end
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (take_o) begin
            cnt_d = next_cnt;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        done_o = (state_q == S_DONE);
    end

endmodule

// File: rtl/nand_hpar_acc.sv
// Parity accumulator: folds lane contributions into the running code.
module nand_hpar_acc #(
    parameter int PAR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic [PAR_W-1:0] even0_i,
    input  logic [PAR_W-1:0] odd0_i,
    input  logic [PAR_W-1:0] even1_i,
    input  logic [PAR_W-1:0] odd1_i,
    output logic [PAR_W-1:0] even_o,
    output logic [PAR_W-1:0] odd_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_o <= '0;
            odd_o  <= '0;
        end else if (clr_i) begin
            even_o <= '0;
            odd_o  <= '0;
        end else if (take_i) begin
            even_o <= even_o ^ even0_i ^ even1_i;
            odd_o  <= odd_o ^ odd0_i ^ odd1_i;
        end
    end

endmodule

// File: rtl/nand_hpar_pack.sv
// Places parities in the result word and interleaves the code bytes.
module nand_hpar_pack
    import nand_hpar_pkg::*;
#(
    parameter int PAR_W  = 12,
    parameter int CODE_W = 2 * PAR_W
) (
    input  logic [PAR_W-1:0]    even_i,
    input  logic [PAR_W-1:0]    odd_i,
    output logic [RESULT_W-1:0] result_o,
    output logic [CODE_W-1:0]   code_o
);

    always_comb begin
        result_o                  = '0;
        result_o[PAR_W-1:0]       = even_i;
        result_o[ODD_BASE+:PAR_W] = odd_i;
    end

    // low even byte, low odd byte, then high even bits below high odd bits
    assign code_o = {odd_i[PAR_W-1:8], even_i[PAR_W-1:8], odd_i[7:0], even_i[7:0]};

endmodule

// File: rtl/nand_hamming_gen.sv
module nand_hamming_gen
    import nand_hpar_pkg::*;
#(
    parameter int SIZE_W = 8,
    localparam int ADDR_W = SIZE_W + 1,
    localparam int CNT_W  = ADDR_W + 1,
    localparam int PAR_W  = COL_BITS + ADDR_W,
    localparam int CODE_W = 2 * PAR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                wide,
    input  logic [SIZE_W-1:0]   sect_units,
    input  logic [15:0]         din,
    input  logic                din_valid,
    output logic [RESULT_W-1:0] result,
    output logic [CODE_W-1:0]   code,
    output logic                done
);

    logic                           take;
    logic [LANES-1:0]               lane_en;
    logic [LANES-1:0][ADDR_W-1:0]   lane_addr;
    logic [LANES-1:0][PAR_W-1:0]    lane_even;
    logic [LANES-1:0][PAR_W-1:0]    lane_odd;
    logic [PAR_W-1:0]               acc_even;
    logic [PAR_W-1:0]               acc_odd;

    nand_hpar_ctrl #(
        .SIZE_W (SIZE_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .en_i         (en),
        .valid_i      (din_valid),
        .wide_i       (wide),
        .sect_units_i (sect_units),
        .take_o       (take),
        .lane0_en_o   (lane_en[0]),
        .lane1_en_o   (lane_en[1]),
        .lane0_addr_o (lane_addr[0]),
        .lane1_addr_o (lane_addr[1]),
        .done_o       (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nand_hpar_lane #(
            .ADDR_W (ADDR_W),
            .PAR_W  (PAR_W)
        ) u_lane (
            .byte_i (din[8*g +: 8]),
            .addr_i (lane_addr[g]),
            .en_i   (lane_en[g]),
            .even_o (lane_even[g]),
            .odd_o  (lane_odd[g])
        );
    end

    nand_hpar_acc #(
        .PAR_W (PAR_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .take_i  (take),
        .even0_i (lane_even[0]),
        .odd0_i  (lane_odd[0]),
        .even1_i (lane_even[1]),
        .odd1_i  (lane_odd[1]),
        .even_o  (acc_even),
        .odd_o   (acc_odd)
    );

    nand_hpar_pack #(
        .PAR_W  (PAR_W),
        .CODE_W (CODE_W)
    ) u_pack (
        .even_i   (acc_even),
        .odd_i    (acc_odd),
        .result_o (result),
        .code_o   (code)
    );

endmodule

// File: rtl/nand_hpar_chk.sv
module nand_hpar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        en,
    input logic        wide,
    input logic [15:0] din,
    input logic        din_valid,
    input logic [31:0] result,
    input logic        done
);

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (result == 32'd0 && !done));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> (done && $stable(result)));

    // R9
    no_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(en && din_valid)) |=> $stable(result));

    // R10
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (wide ? (din == 16'd0) : (din[7:0] == 8'd0))) |=> $stable(result));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(en && din_valid && !clr));

endmodule

bind nand_hamming_gen nand_hpar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .en        (en),
    .wide      (wide),
    .din       (din),
    .din_valid (din_valid),
    .result    (result),
    .done      (done)
);

// File: tb/tb_nand_hamming_gen.sv
module tb_nand_hamming_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr;
    logic        en;
    logic        wide;
    logic [7:0]  sect_units;
    logic [15:0] din;
    logic        din_valid;
    logic [31:0] result;
    logic [23:0] code;
    logic        done;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    // reference model state
    logic [11:0] m_even;
    logic [11:0] m_odd;
    int          m_cnt;
    bit          m_done;
    logic [7:0]  mem [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_hamming_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .en         (en),
        .wide       (wide),
        .sect_units (sect_units),
        .din        (din),
        .din_valid  (din_valid),
        .result     (result),
        .code       (code),
        .done       (done)
    );

    // every set bit flips one column parity per index bit and one line parity per address bit
    function automatic void model_byte(input logic [7:0] b, input int a);
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin
                for (int k = 0; k < 3; k++) begin
                    if (i[k]) m_odd[k] = ~m_odd[k];
                    else      m_even[k] = ~m_even[k];
                end
                for (int k = 0; k < 9; k++) begin
                    if (a[k]) m_odd[3+k] = ~m_odd[3+k];
                    else      m_even[3+k] = ~m_even[3+k];
                end
            end
        end
    endfunction

    function automatic void model_clear();
        m_even = '0;
        m_odd  = '0;
        m_cnt  = 0;
        m_done = 1'b0;
    endfunction

    function automatic void model_beat(input bit w, input logic [15:0] d);
        int total;
        total = 2 * (int'(sect_units) + 1);
        if (w) begin
            if (m_cnt < total)     model_byte(d[7:0], m_cnt);
            if (m_cnt + 1 < total) model_byte(d[15:8], m_cnt + 1);
            m_cnt += 2;
        end else begin
            model_byte(d[7:0], m_cnt);
            m_cnt += 1;
        end
        if (m_cnt >= total) m_done = 1'b1;
    endfunction

    function automatic logic [31:0] exp_result();
        return {4'b0, m_odd, 4'b0, m_even};
    endfunction

    function automatic logic [23:0] exp_code();
        return {m_odd[11:8], m_even[11:8], m_odd[7:0], m_even[7:0]};
    endfunction

    task automatic check32(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        n_checks++;
        if (result !== exp_result() || code !== exp_code() || done !== m_done) begin
            n_errors++;
            $display("FAIL %s: got result=%h code=%h done=%b expected result=%h code=%h done=%b",
                     req, result, code, done, exp_result(), exp_code(), m_done);
        end
    endtask

    // called at a falling edge; returns at the following falling edge
    task automatic beat(input bit e, input bit v, input bit w, input logic [15:0] d);
        en = e; din_valid = v; wide = w; din = d;
        @(posedge clk);
        if (e && v && !m_done) model_beat(w, d);
        @(negedge clk);
        din_valid = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run_mem_narrow();
        for (int j = 0; j < 512; j++) beat(1'b1, 1'b1, 1'b0, {8'h00, mem[j]});
    endtask

    task automatic syndrome_test(input int a, input int bi);
        logic [31:0] r1;
        logic [31:0] r2;
        logic [11:0] sv;
        sect_units = 8'd255;
        do_clear();
        run_mem_narrow();
        r1 = result;
        mem[a][bi] = ~mem[a][bi];
        do_clear();
        run_mem_narrow();
        r2 = result;
        mem[a][bi] = ~mem[a][bi];
        sv = {a[8:0], bi[2:0]};
        // R2 R3: single flip decodes to address and bit index
        check32("R2/R3 syndrome", r1 ^ r2, {4'b0, sv, 4'b0, ~sv});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clr = 1'b0; en = 1'b0; wide = 1'b0;
        din = '0; din_valid = 1'b0; sect_units = 8'd255;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2 R3 R5: byte 0x01 at address 0, high lane garbage
        beat(1'b1, 1'b1, 1'b0, 16'hAA01);
        check32("R2/R5 byte at addr 0", result, 32'h0000_0FFF);
        // R3: byte 0x80 at address 1
        beat(1'b1, 1'b1, 1'b0, 16'h5580);
        check32("R3 byte at addr 1", result, 32'h000F_000F);
        // R4 packing
        check32("R4 code packing", {8'h00, code}, 32'h0000_0F0F);
        // R9: enable low, strobe low
        beat(1'b0, 1'b1, 1'b0, 16'h00FF);
        beat(1'b1, 1'b0, 1'b0, 16'h00FF);
        check32("R9 ignored beats", result, 32'h000F_000F);
        beat(1'b1, 1'b1, 1'b0, 16'h0001);
        check32("R9 address not advanced", result, 32'h001F_0FE0);

        // R8: clear with a simultaneous beat
        en = 1'b1; din_valid = 1'b1; din = 16'hFFFF; wide = 1'b1;
        do_clear();
        din_valid = 1'b0;
        check32("R8 clear wins", result, 32'h0);
        check_all("R8 clear state");
        beat(1'b1, 1'b1, 1'b0, 16'h0001);
        check32("R8 address restarts", result, 32'h0000_0FFF);

        // R6 R7: 16-byte sector in wide mode, then extra beats
        sect_units = 8'd7;
        do_clear();
        for (int j = 0; j < 8; j++) begin
            beat(1'b1, 1'b1, 1'b1, 16'($urandom));
            if (j == 6) check_all("R7 not done before last beat");
        end
        check_all("R6/R7 wide sector done");
        beat(1'b1, 1'b1, 1'b1, 16'hBEEF);
        beat(1'b1, 1'b1, 1'b0, 16'h0077);
        check_all("R7 beats after done ignored");

        // R7: one-beat sector in wide mode
        sect_units = 8'd0;
        do_clear();
        beat(1'b1, 1'b1, 1'b1, 16'h8001);
        check_all("R7 one-beat sector");
        // R5 R7: two-byte sector narrow
        do_clear();
        beat(1'b1, 1'b1, 1'b0, 16'h00C3);
        check_all("R5 first of two");
        beat(1'b1, 1'b1, 1'b0, 16'h003C);
        check_all("R5/R7 narrow sector done");

        // R6: mode switch at odd address, overflow byte dropped
        sect_units = 8'd1;
        do_clear();
        beat(1'b1, 1'b1, 1'b0, 16'h0011);
        beat(1'b1, 1'b1, 1'b1, 16'h2233);
        check_all("R6 odd-address wide beat");
        beat(1'b1, 1'b1, 1'b1, 16'h4455);
        check_all("R6 overflow byte dropped");

        // R10: all-zero full sector
        sect_units = 8'd255;
        do_clear();
        for (int j = 0; j < 256; j++) beat(1'b1, 1'b1, 1'b1, 16'h0000);
        check32("R10 zero code", {8'h00, code}, 32'h0);
        check_all("R10 zero sector done");

        // random sectors with gaps and mixed widths
        for (int s = 0; s < 3; s++) begin
            bit w_sel;
            sect_units = (s == 2) ? 8'd255 : 8'($urandom_range(1, 60));
            w_sel = s[0];
            do_clear();
            for (int j = 0; j < 600 && !m_done; j++) begin
                beat(($urandom % 8) != 0, ($urandom % 6) != 0, w_sel, 16'($urandom));
                if ((j % 97) == 0) check_all("R5/R6 random sector progress");
            end
            check_all("R7 random sector final");
        end

        // R2 R3: single-bit flips
        for (int j = 0; j < 512; j++) mem[j] = 8'($urandom);
        syndrome_test(511, 7);
        syndrome_test(0, 0);
        syndrome_test(int'($urandom_range(0, 511)), int'($urandom_range(0, 7)));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule